// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Memory

This block is a small byte-addressed data store. It is organised as rows that are each eight bytes wide. A single request port accepts either a load or a store of 1, 2, 4 or 8 bytes. The block splits the byte address into a row number (the upper bits) and a byte position within the row (the low three bits).

A load picks the addressed lane out of the row and returns it right-aligned and zero-extended. The result arrives one cycle after the request, together with a valid strobe. A store updates only the bytes of the addressed lane. It does this by reading the row, clearing the lane, and OR-ing the new bytes into place. The write takes effect at the clock edge that ends the request cycle.

A per-access swap option reverses the byte order within the access width. For stores the reversal happens before the merge, and for loads it happens after the extraction. A request whose byte position is not a multiple of its width, or whose width code is not one of the four legal codes, is refused: memory is left untouched and an error pulse is raised.

Top module: `subword_lane_mem`

## Requirements
- R1: The row number is reqAddr shifted right by 3, and the byte position is reqAddr[2:0]. An access to one row never alters any other row.
- R2: A legal load of N bytes at position P returns bytes P..P+N-1 of the row on rspRdata. The byte at P lands in bits [7:0], and all bits above 8N are zero. rspValid is high for exactly the cycle after a load request.
- R3: A legal store narrower than 8 bytes changes only bytes P..P+N-1 of the addressed row. Every other byte of the row keeps its value.
- R4: A legal 8-byte store replaces the whole row with reqWdata.
- R5: With reqSwap set, a load returns the extracted N-byte lane with its byte order reversed within N bytes.
- R6: With reqSwap set, a store reverses the low N bytes of reqWdata before writing them into the lane.
- R7: After reset, every row that has not been written reads as zero.
- R8: A request whose position is not a multiple of its width raises rspError for exactly one cycle, in the cycle after the request. It leaves memory unchanged. If it is a load, it still raises rspValid, with rspRdata equal to zero.
- R9: A width code on reqWidth other than 1, 2, 4 or 8 is handled exactly like a misaligned request (R8).
- R10: The bits of reqWdata above the access width have no effect on memory.
- R11: While reset is held and right after it is released, rspValid, rspError and rspRdata are zero.
- R12: A cycle with reqValid low raises neither rspValid nor rspError in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address |
| reqWidth | input | 4 | Access size in bytes: 1, 2, 4 or 8 |
| reqSwap | input | 1 | Reverse bytes within the access width |
| reqWdata | input | 64 | Store data, right-aligned |
| rspValid | output | 1 | Load response present |
| rspError | output | 1 | Previous request was refused |
| rspRdata | output | 64 | Load data, right-aligned |

## Verification
Two things can fall in the same cycle. The first is a load response being presented while a new store is writing a row. The second is a store landing at an edge just before a load of the same row is served. The bench provokes both by issuing requests back to back with no idle cycles: a store followed at once by a load of the same row, and a load followed at once by a store to that row. The bench then checks two results. The load that follows the store must see the merged bytes. The response of the earlier load must still hold the bytes from before the store. Each result is judged against a byte-array model kept in the bench, which is compared on every clock.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  localparam int ROW_BYTES = 8;
  localparam int ROW_BITS  = ROW_BYTES * 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic fullRow;
    logic bad;
    logic swap;
  } laneCtl_t;

  function automatic logic [ROW_BITS-1:0] byteFlip(input logic [ROW_BITS-1:0] d,
                                                   input logic [3:0] nBytes);
    logic [ROW_BITS-1:0] r;
    r = '0;
    for (int k = 0; k < ROW_BYTES; k++) begin
      if (k < int'(nBytes)) r[k*8 +: 8] = d[(int'(nBytes) - 1 - k)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/lane_mem_ctrl.sv
module lane_mem_ctrl
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic                reqValid,
  input  logic                reqStore,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [3:0]          reqWidth,
  input  logic                reqSwap,
  output laneCtl_t            ctl,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [5:0]          laneShift,
  output logic [ROW_BITS-1:0] laneMask,
  output logic [3:0]          nBytes
);
  logic [OFF_W-1:0] byteOff;
  logic             widthOk;
  logic             aligned;

  assign byteOff   = reqAddr[OFF_W-1:0];
  assign rowIdx    = reqAddr[ADDR_W-1:OFF_W];
  assign laneShift = {byteOff, 3'b000};

  always_comb begin
    widthOk  = 1'b1;
    laneMask = '1;
    nBytes   = 4'd8;
    case (reqWidth)
      4'd1: begin laneMask = 64'h0000_0000_0000_00FF; nBytes = 4'd1; end
      4'd2: begin laneMask = 64'h0000_0000_0000_FFFF; nBytes = 4'd2; end
      4'd4: begin laneMask = 64'h0000_0000_FFFF_FFFF; nBytes = 4'd4; end
      4'd8: ;
      default: widthOk = 1'b0;
    endcase
  end

  assign aligned = (({1'b0, byteOff} & (reqWidth - 4'd1)) == 4'd0);

  always_comb begin
    ctl.bad     = reqValid & ~(widthOk & aligned);
    ctl.rdEn    = reqValid & ~reqStore;
    ctl.wrEn    = reqValid & reqStore & ~ctl.bad;
    ctl.fullRow = (reqWidth == 4'd8);
    ctl.swap    = reqSwap;
  end
endmodule

// File: rtl/lane_mem_dp.sv
module lane_mem_dp
  import lane_mem_pkg::*;
#(
  parameter int ROW_W = 5,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneCtl_t            ctl,
  input  logic [ROW_W-1:0]    rowIdx,
  input  logic [5:0]          laneShift,
  input  logic [ROW_BITS-1:0] laneMask,
  input  logic [3:0]          nBytes,
  input  logic [ROW_BITS-1:0] wdata,
  output logic                rspValid,
  output logic                rspError,
  output logic [ROW_BITS-1:0] rspRdata
);
  logic [ROW_BITS-1:0] rowMem [DEPTH];
  logic [DEPTH-1:0]    rowWritten;
  logic [ROW_BITS-1:0] curRow, placedMask, extracted, loadVal;
  logic [ROW_BITS-1:0] storeData, merged;

  assign curRow     = rowWritten[rowIdx] ? rowMem[rowIdx] : '0;
  assign placedMask = laneMask << laneShift;
  assign extracted  = (curRow & placedMask) >> laneShift;
  assign loadVal    = ctl.swap ? byteFlip(extracted, nBytes) : extracted;
  assign storeData  = ctl.swap ? byteFlip(wdata & laneMask, nBytes) : (wdata & laneMask);
  assign merged     = ctl.fullRow ? storeData
                                  : ((curRow & ~placedMask) | (storeData << laneShift));

  always_ff @(posedge clk) begin
    if (ctl.wrEn) rowMem[rowIdx] <= merged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rowWritten <= '0;
    else if (ctl.wrEn) rowWritten[rowIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= ctl.rdEn;
      rspError <= ctl.bad;
      if (ctl.rdEn) rspRdata <= ctl.bad ? '0 : loadVal;
    end
  end
endmodule

// File: rtl/subword_lane_mem.sv
module subword_lane_mem
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqWidth,
  input  logic              reqSwap,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic              rspError,
  output logic [63:0]       rspRdata
);
  laneCtl_t            ctl;
  logic [ROW_W-1:0]    rowIdx;
  logic [5:0]          laneShift;
  logic [ROW_BITS-1:0] laneMask;
  logic [3:0]          nBytes;

  lane_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .reqValid(reqValid), .reqStore(reqStore), .reqAddr(reqAddr),
    .reqWidth(reqWidth), .reqSwap(reqSwap), .ctl(ctl), .rowIdx(rowIdx),
    .laneShift(laneShift), .laneMask(laneMask), .nBytes(nBytes)
  );

  lane_mem_dp #(.ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rowIdx(rowIdx), .laneShift(laneShift),
    .laneMask(laneMask), .nBytes(nBytes), .wdata(reqWdata),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/subword_lane_mem_chk.sv
module subword_lane_mem_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqStore,
  input logic [2:0]  reqOff,
  input logic [3:0]  reqWidth,
  input logic        rspValid,
  input logic        rspError,
  input logic [63:0] rspRdata
);
  logic legalCode;
  assign legalCode = (reqWidth == 4'd1) || (reqWidth == 4'd2) ||
                     (reqWidth == 4'd4) || (reqWidth == 4'd8);

  p_load_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore) |=> rspValid);

  p_byte_zero_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore && reqWidth == 4'd1) |=> (rspRdata[63:8] == 56'd0));

  p_misalign_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && legalCode && (({1'b0, reqOff} & (reqWidth - 4'd1)) != 4'd0)) |=> rspError);

  p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspError && rspValid) |-> (rspRdata == 64'd0));

  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !legalCode) |=> rspError);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspError));

  p_store_no_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore) |=> !rspValid);
endmodule

bind subword_lane_mem subword_lane_mem_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
  .reqOff(reqAddr[2:0]), .reqWidth(reqWidth), .rspValid(rspValid),
  .rspError(rspError), .rspRdata(rspRdata)
);

// File: tb/subword_lane_mem_bench.sv
`timescale 1ns/1ps
module subword_lane_mem_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqStore = 1'b0, reqSwap = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0]    reqWidth = 4'd1;
  logic [63:0]   reqWdata = '0;
  logic          rspValid, rspError;
  logic [63:0]   rspRdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] refBytes [256];

  always #2 clk = ~clk;

  subword_lane_mem #(.ADDR_W(AW)) u_subword_lane_mem (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqWidth(reqWidth), .reqSwap(reqSwap), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata)
  );

  function automatic bit isLegal(int addr, int w);
    if (!(w == 1 || w == 2 || w == 4 || w == 8)) return 1'b0;
    return (addr % w) == 0;
  endfunction

  function automatic logic [63:0] flipN(logic [63:0] v, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[8*i +: 8] = v[8*(w-1-i) +: 8];
    return r;
  endfunction

  task automatic step(bit vld, bit st, int addr, int w, bit sw,
                      logic [63:0] data, string tag);
    bit expV, expE;
    logic [63:0] expD;
    logic [63:0] d;
    expV = vld && !st;
    expE = vld && !isLegal(addr, w);
    expD = '0;
    if (vld && !st && !expE) begin
      for (int i = 0; i < w; i++) expD[8*i +: 8] = refBytes[addr+i];
      if (sw) expD = flipN(expD, w);
    end
    if (vld && st && !expE) begin
      d = sw ? flipN(data, w) : data;
      for (int i = 0; i < w; i++) refBytes[addr+i] = d[8*i +: 8];
    end
    reqValid = vld; reqStore = st; reqAddr = AW'(addr);
    reqWidth = 4'(w); reqSwap = sw; reqWdata = data;
    @(negedge clk);
    checks++;
    if (rspValid !== expV || rspError !== expE || (expV && rspRdata !== expD)) begin
      failures++;
      $display("FAIL %s: valid=%0b err=%0b data=%h expected valid=%0b err=%0b data=%h",
               tag, rspValid, rspError, rspRdata, expV, expE, expD);
    end
  endtask

  task automatic ld(int addr, int w, bit sw, string tag);
    step(1'b1, 1'b0, addr, w, sw, 64'd0, tag);
  endtask
  task automatic st(int addr, int w, bit sw, logic [63:0] data, string tag);
    step(1'b1, 1'b1, addr, w, sw, data, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) refBytes[i] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspError !== 1'b0 || rspRdata !== 64'd0) begin
      failures++;
      $display("FAIL R11 reset: valid=%0b err=%0b data=%h expected 0 0 0", rspValid, rspError, rspRdata);
    end
    rstN = 1'b1;
    step(1'b0, 1'b0, 0, 1, 1'b0, 64'd0, "R11 after release");
    ld(8'h40, 8, 1'b0, "R7 unwritten row");
    ld(8'h05, 1, 1'b0, "R7 unwritten byte");
    st(8'h10, 8, 1'b0, 64'h1122_3344_5566_7788, "R4 full store");
    ld(8'h10, 8, 1'b0, "R4 full readback");
    ld(8'h13, 1, 1'b0, "R2 byte load");
    ld(8'h16, 2, 1'b0, "R2 half load");
    ld(8'h14, 4, 1'b0, "R2 word load");
    st(8'h11, 1, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB, "R3 R10 byte store");
    ld(8'h10, 8, 1'b0, "R3 R10 merged row");
    st(8'h1A, 2, 1'b1, 64'h0000_0000_0000_BEEF, "R6 swapped store");
    ld(8'h1A, 2, 1'b0, "R6 raw readback");
    ld(8'h1A, 2, 1'b1, "R5 swapped half load");
    ld(8'h14, 4, 1'b1, "R5 swapped word load");
    ld(8'h10, 8, 1'b1, "R5 swapped row load");
    ld(8'h12, 1, 1'b1, "R5 swap single byte");
    st(8'h12, 4, 1'b0, 64'hDEAD_BEEF, "R8 misaligned store");
    ld(8'h10, 8, 1'b0, "R8 memory unchanged");
    ld(8'h11, 2, 1'b0, "R8 misaligned load zero");
    st(8'h00, 3, 1'b0, 64'h1234, "R9 bad width store");
    ld(8'h00, 8, 1'b0, "R9 memory unchanged");
    ld(8'h00, 0, 1'b0, "R9 bad width load");
    step(1'b0, 1'b1, 8'h10, 8, 1'b0, 64'hFFFF, "R12 idle no effect");
    ld(8'h10, 8, 1'b0, "R12 row intact");
    st(8'hF8, 8, 1'b0, 64'hA5A5_0000_5A5A_FFFF, "R1 last row store");
    st(8'h00, 8, 1'b0, 64'h0102_0304_0506_0708, "R1 first row store");
    ld(8'h08, 8, 1'b0, "R1 neighbour untouched");
    ld(8'hFE, 2, 1'b0, "R1 last row lane");
    ld(8'h04, 4, 1'b0, "R1 first row lane");
    ld(8'h20, 8, 1'b0, "R2 load before store");
    st(8'h24, 4, 1'b0, 64'hCAFE_F00D, "R3 store after load");
    ld(8'h20, 8, 1'b0, "R3 load after store");
    st(8'h27, 1, 1'b1, 64'h77, "R6 swap width one");
    ld(8'h24, 4, 1'b0, "R3 lane merge top byte");
    step(1'b0, 1'b0, 0, 1, 1'b0, 64'd0, "R12 final idle");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule